// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs management transactions to an Ethernet PHY over the two-wire MDC/MDIO interface. Software loads one 32-bit management word that already holds every field of the frame: start code, opcode, PHY address, register address, turnaround code and data. The engine sends a preamble of ones, then shifts the word out MSB first. For a read it releases the data line and collects the PHY's 16 data bits into the low half of the same word. Software then reads the result back through `rd_data`.

MDC is made from the system clock by a divider that is chosen per transaction. An idle flag tells software when a new word may be written. The whole port works only while its enable input is high. Dropping the enable aborts any frame in flight.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `rd_data` is 0. While `idle` is 1, `mdc` and `mdio_oe` stay 0.
- R2: A write is accepted when `wr_en`, `idle` and `port_en` are all 1 on the same rising clock edge. `rd_data` takes `wr_data` and `idle` reads 0 from the next cycle. The frame then lasts exactly 64*D clocks, after which `idle` returns to 1.
- R3: A `wr_en` pulse while a frame is running is ignored. Bits 31:16 of `rd_data` stay unchanged, and the completed word holds only the original fields plus any read data.
- R4: While `port_en` is 0, writes are ignored and `idle` stays 1. Clearing `port_en` during a frame aborts it: from the next cycle `idle` is 1 and `mdc` and `mdio_oe` are 0.
- R5: `div_sel` is captured at acceptance and sets D: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 48 clocks per MDC period. Each MDC period is low for the first D/2 clocks and high for the last D/2.
- R6: The first 32 MDC periods of every frame drive `mdio_o` high with `mdio_oe` at 1, as a preamble.
- R7: Periods 32 to 63 carry word bits 31 down to 0, one bit per period, MSB first. Each bit changes at the falling MDC boundary. The word layout is: start code 01 in bits 31:30, opcode in 29:28 (10 = read, 01 = write), PHY address in 27:23, register address in 22:18, turnaround code 10 in 17:16 and data in 15:0.
- R8: With opcode 10, `mdio_oe` drops for the period of word bit 16 (frame period 47) and for the 16 data periods. `mdio_i` is sampled at each MDC rising edge of the data periods into bits 15:0, MSB first.
- R9: With any opcode other than 10, `mdio_oe` stays 1 for all 64 periods and `rd_data` is unchanged at the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 2 | MDC divider select, captured at acceptance |
| wr_en | input | 1 | Write strobe for the management word |
| wr_data | input | 32 | Management word to send |
| rd_data | output | 32 | Current management word, including returned read data |
| idle | output | 1 | 1 when a new word can be accepted |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable (1 = drive) |
| mdio_i | input | 1 | Data line input value |

## Verification
The checker tests the following on every cycle:
- `idle` drops after an accepted write.
- The upper half of the word holds steady during a frame.
- Disabling the port forces it quiet at once.
- An idle port drives nothing.
- Non-read frames keep the line driven.

Only the bench's scenarios can show the other properties:
- The serial order of the preamble and the fields.
- The exact frame length and MDC duty for each divider setting.
- The point where the line is released.
- The reassembly of the PHY's data bits.
- That a write into a busy or disabled port leaves the final word intact.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int WORD_W  = 32;
    localparam int CNT_W   = 6;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic [1:0]  start;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [1:0]  ta;
        logic [15:0] data;
    } mgmt_word_t;

    function automatic logic [CNT_W-1:0] divisor(input logic [1:0] sel);
        case (sel)
            2'd0:    divisor = CNT_W'(8);
            2'd1:    divisor = CNT_W'(16);
            2'd2:    divisor = CNT_W'(32);
            default: divisor = CNT_W'(48);
        endcase
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             end_tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;

    assign half = div >> 1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == div - 1'b1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign mdc       = run && (cnt >= half);
    assign rise_tick = run && (cnt == half - 1'b1);
    assign end_tick  = run && (cnt == div - 1'b1);

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int IDX_W    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        div_sel,
    input  logic              rise_tick,
    input  logic              end_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic [CNT_W-1:0]  div_q,
    output logic [WORD_W-1:0] word,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int FRAME_BITS = PRE_BITS + WORD_W;
    localparam int LAST_POS   = FRAME_BITS - 1;
    localparam int TA2_POS    = PRE_BITS + 15;
    localparam int DATA_POS   = PRE_BITS + 16;

    logic [IDX_W-1:0] idx;
    logic             is_rd;
    logic             accept;
    logic [IDX_W-1:0] rel;
    logic [4:0]       bsel;
    logic             in_word;
    mgmt_word_t       wview;

    assign wview   = mgmt_word_t'(wr_data);
    assign accept  = wr_en && !busy && port_en;
    assign in_word = idx >= IDX_W'(PRE_BITS);
    assign rel     = idx - IDX_W'(PRE_BITS);
    assign bsel    = 5'd31 - rel[4:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            word  <= '0;
            is_rd <= 1'b0;
            div_q <= divisor(2'd0);
        end else if (!port_en) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            idx   <= '0;
            word  <= wr_data;
            is_rd <= (wview.op == OP_READ);
            div_q <= divisor(div_sel);
        end else if (busy) begin
            if (rise_tick && is_rd && idx >= IDX_W'(DATA_POS)) begin
                word[bsel] <= mdio_i;
            end
            if (end_tick) begin
                if (idx == IDX_W'(LAST_POS)) begin
                    busy <= 1'b0;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign mdio_o  = (busy && in_word) ? word[bsel] : 1'b1;
    assign mdio_oe = busy && !(is_rd && idx >= IDX_W'(TA2_POS));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        port_en,
    input  logic [1:0]  div_sel,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int IDX_W = $clog2(PRE_BITS + WORD_W);

    logic             busy;
    logic             rise_tick;
    logic             end_tick;
    logic [CNT_W-1:0] div_q;

    mdio_clkgen #(.CNT_W(CNT_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .end_tick  (end_tick)
    );

    mdio_frame #(.PRE_BITS(PRE_BITS), .IDX_W(IDX_W)) u_frm (
        .clk       (clk),
        .rst       (rst),
        .port_en   (port_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .div_sel   (div_sel),
        .rise_tick (rise_tick),
        .end_tick  (end_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .div_q     (div_q),
        .word      (rd_data),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    assign idle = !busy;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        port_en,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_oe
);
    p_idle_drop_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en && idle && port_en |=> !idle);

    p_upper_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !idle && port_en |=> $stable(rd_data[31:16]));

    p_disable_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> idle && !mdc && !mdio_oe);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        idle |-> !mdc && !mdio_oe);

    p_write_drive_r9: assert property (@(posedge clk) disable iff (rst)
        !idle && rd_data[29:28] != 2'b10 |-> mdio_oe);

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .port_en (port_en),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .idle    (idle),
    .mdc     (mdc),
    .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mdio_master u0 (
        .clk(clk), .rst(rst), .port_en(port_en), .div_sel(div_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .idle(idle),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int div_of(input bit [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 32;
            default: return 48;
        endcase
    endfunction

    function automatic bit exp_bit(input logic [31:0] w, input int k);
        return (k < 32) ? 1'b1 : w[63-k];
    endfunction

    function automatic bit phy_bit(input logic [15:0] pd, input int k);
        if (k >= 48) return pd[63-k];
        if (k == 47) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] mk_word(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
    endfunction

    task automatic run_frame(input logic [31:0] w, input bit [1:0] s,
                             input logic [15:0] pd, input int inj);
        bit rd = (w[29:28] == 2'b10);
        int d = div_of(s);
        int rises = 0, busy_cyc = 0, hi = 0;
        int bad_pre = 0, bad_bits = 0, bad_oe = 0;
        bit prev = 1'b0;
        bit first_mdc;
        bit eoe;
        logic [31:0] exp_w;
        mdio_i = phy_bit(pd, 0);
        @(negedge clk);
        wr_data = w; div_sel = s; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(idle == 1'b0, "R2 idle low after accept", 32'(idle), 32'h0);
        first_mdc = mdc;
        while (!idle && busy_cyc < 5000) begin
            busy_cyc++;
            if (mdc) hi++;
            if (mdc && !prev) begin
                eoe = !(rd && rises >= 47);
                if (mdio_oe !== eoe) bad_oe++;
                if (eoe && mdio_o !== exp_bit(w, rises)) begin
                    if (rises < 32) bad_pre++; else bad_bits++;
                end
                rises++;
                mdio_i = phy_bit(pd, rises);
            end
            prev = mdc;
            if (busy_cyc == inj) begin
                wr_en = 1'b1; wr_data = ~w;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        exp_w = rd ? {w[31:16], pd} : w;
        chk(first_mdc == 1'b0, "R5 mdc low at start of period", 32'(first_mdc), 32'h0);
        chk(busy_cyc == 64*d, "R2 frame length", busy_cyc, 64*d);
        chk(hi == 32*d, "R5 mdc high clocks", hi, 32*d);
        chk(rises == 64, "R7 mdc periods", rises, 64);
        chk(bad_pre == 0, "R6 preamble bits", bad_pre, 0);
        chk(bad_bits == 0, "R7 frame bits", bad_bits, 0);
        if (rd) chk(bad_oe == 0, "R8 read release", bad_oe, 0);
        else    chk(bad_oe == 0, "R9 write drive", bad_oe, 0);
        if (rd)       chk(rd_data == exp_w, "R8 read data", rd_data, exp_w);
        else if (inj > 0) chk(rd_data == exp_w, "R3 busy write ignored", rd_data, exp_w);
        else          chk(rd_data == exp_w, "R9 word kept", rd_data, exp_w);
        chk(idle == 1'b1, "R2 idle after frame", 32'(idle), 32'h1);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] wa;
        void'($urandom(32'h5eed_0042));
        port_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(idle == 1'b1, "R1 reset idle", 32'(idle), 32'h1);
        chk(mdc == 1'b0, "R1 reset mdc", 32'(mdc), 32'h0);
        chk(mdio_oe == 1'b0, "R1 reset oe", 32'(mdio_oe), 32'h0);
        chk(rd_data == 32'h0, "R1 reset word", rd_data, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // directed corner cases
        run_frame(mk_word(1'b1, 5'd31, 5'd31, 16'h0000), 2'd2, 16'hA5C3, 0);
        run_frame(mk_word(1'b0, 5'd0, 5'd1, 16'hFFFF), 2'd3, 16'h0000, 0);
        run_frame(mk_word(1'b1, 5'd1, 5'd0, 16'h0000), 2'd0, 16'hFFFF, 30);
        run_frame(mk_word(1'b0, 5'd9, 5'd3, 16'h1234), 2'd1, 16'h0000, 100);

        // random frames
        for (int i = 0; i < 16; i++) begin
            run_frame(mk_word(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom)),
                      2'($urandom % 2), 16'($urandom),
                      (i % 3 == 0) ? 5 + int'($urandom % 200) : 0);
        end

        // R4: abort by disable, then disabled write ignored
        wa = mk_word(1'b0, 5'd4, 5'd5, 16'hBEEF);
        @(negedge clk);
        wr_data = wa; div_sel = 2'd0; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (50) @(negedge clk);
        port_en = 1'b0;
        @(negedge clk);
        chk(idle == 1'b1, "R4 abort idle", 32'(idle), 32'h1);
        chk(mdc == 1'b0, "R4 abort mdc", 32'(mdc), 32'h0);
        chk(mdio_oe == 1'b0, "R4 abort oe", 32'(mdio_oe), 32'h0);
        wr_data = ~wa; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk(idle == 1'b1, "R4 disabled write idle", 32'(idle), 32'h1);
        chk(rd_data == wa, "R4 disabled write ignored", rd_data, wa);
        port_en = 1'b1;
        @(negedge clk);
        chk(idle == 1'b1, "R4 re-enable idle", 32'(idle), 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule